// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block sits between a host register port and a 12-bit successive-approximation converter. The host selects one of eight external inputs or the internal temperature input, and picks one of three trigger sources: a command bit, the falling edge of an external convert pin, or a one-cycle pulse from a timer. The block then issues conversion start pulses and collects the 12-bit straight-binary codes (1 LSB = full scale / 4096) that the converter returns through a start/done handshake.

A conversion runs once per trigger in single mode. In continuous mode the block restarts it as soon as the previous one finishes. In capture mode one trigger starts an autonomous run. Every result goes to an external memory through a write port, tagged with its channel, at addresses that count up from a programmed base. The run ends after a programmed number of samples. Conversions outside a capture raise a completion flag and an interrupt pulse. A trigger that arrives while the converter is busy is dropped and recorded in a sticky overrun flag. While the power bit is clear, every trigger is refused.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset all three registers read zero, and `conv_start_o`, `irq_o` and `mem_we_o` are low.
- R2: While the power bit (control bit 0) is clear, no trigger starts a conversion or sets overrun. Clearing it during continuous operation lets the current conversion finish and prevents any further start.
- R3: Control bits [8:5] select the channel. Values 0..7 drive `conv_chan_o` with that value, and any value of 8 or above drives 8 (the temperature input). The channel is captured at each start.
- R4: With source field (control bits [3:2]) = 0, writing register 1 with bit 0 set pulses `conv_start_o` in the cycle after the write edge.
- R5: With source = 1, only a falling edge of `cnv_pin_i` starts a conversion. It passes a two-flop synchroniser, so the start pulse appears three cycles after the pin is sampled low. A rising edge starts nothing.
- R6: With source = 2, a high `tmr_pulse_i` starts a conversion, and the start pulse appears in the next cycle.
- R7: Triggers from sources other than the selected one are ignored.
- R8: Outside a capture, the code returned with `conv_done_i` is stored in status bits [11:0], status bit 12 (done) is set, and `irq_o` is high for exactly the one cycle after the `conv_done_i` cycle.
- R9: With control bit 1 (continuous) set, each completion issues the next start in the following cycle, until the bit is cleared.
- R10: A selected trigger seen while a conversion is outstanding is ignored and sets sticky status bit 13. Writing register 1 with bit 1 set clears status bits 12..14.
- R11: With control bit 4 (capture) set, each result is written as {channel[3:0], code[11:0]}. The first sample goes to the base address (register 2 bits [7:0]), and the address increments per sample and wraps. A capture never raises `irq_o` or status bit 12.
- R12: A capture ends after the sample count in register 2 bits [15:8] is reached (0 means 256). It then sets status bit 14 and returns to idle (status bit 15, busy, low).
- R13: Register 0 reads back control bits [8:0]. Register 1 reads {busy, capture-done, overrun, done, result[11:0]} from bit 15 down. Register 2 reads back {count, base}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| cnv_pin_i | input | 1 | External convert pin, asynchronous |
| tmr_pulse_i | input | 1 | Timer trigger pulse |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 4 | Channel for the current conversion |
| conv_done_i | input | 1 | Converter result valid |
| conv_code_i | input | 12 | Converter result |
| mem_we_o | output | 1 | Capture memory write |
| mem_addr_o | output | 8 | Capture memory address |
| mem_wdata_o | output | 16 | Capture entry {channel, code} |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
A start is due one cycle after a command write or timer pulse is clocked in, and three cycles after the pin is first sampled low. Flags, the interrupt pulse and capture writes are due one cycle after the `conv_done_i` cycle, and a continuous restart is due in that same following cycle. The bench stamps every start, completion, interrupt and memory write with a free-running cycle number, and checks the exact distance between the stimulus stamp and the event stamp. It reads registers only at falling edges, once the expected event has already been logged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CODE_W    = 12;
  localparam int CHAN_W    = 4;
  localparam int REG_W     = 16;
  localparam int ENTRY_W   = CHAN_W + CODE_W;
  localparam int TEMP_CHAN = 8;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_PIN = 2'd1,
    SRC_TMR = 2'd2,
    SRC_OFF = 2'd3
  } trig_src_e;

  // packed LSB first: pwr[0] cont[1] src[3:2] cap[4] chan[8:5]
  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              cap;
    trig_src_e         src;
    logic              cont;
    logic              pwr;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic {ST_IDLE, ST_CONV} seq_st_e;

  function automatic logic [CHAN_W-1:0] map_chan(input logic [CHAN_W-1:0] f);
    return (f > CHAN_W'(TEMP_CHAN)) ? CHAN_W'(TEMP_CHAN) : f;
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [AW-1:0]     base_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              sw_start_o,
  output logic              clr_o,
  input  logic [CODE_W-1:0] result_i,
  input  logic              done_i,
  input  logic              ovr_i,
  input  logic              capdone_i,
  input  logic              busy_i
);
  localparam int DMA_W = AW + CNT_W;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_DMA  = 2'd2;

  ctrl_t             ctrl_q;
  logic [AW-1:0]     base_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == A_DMA)  {cnt_q, base_q} <= wdata_i[DMA_W-1:0];
    end
  end

  assign sw_start_o = we_i && (addr_i == A_CMD) && wdata_i[0];
  assign clr_o      = we_i && (addr_i == A_CMD) && wdata_i[1];
  assign ctrl_o     = ctrl_q;
  assign base_o     = base_q;
  assign cnt_o      = cnt_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_CMD:   rdata_o = {busy_i, capdone_i, ovr_i, done_i, result_i};
      A_DMA:   rdata_o[DMA_W-1:0] = {cnt_q, base_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // idle-high pin: reset to ones so no edge is seen after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q && !sync_q[STAGES-1];

  p_fall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/adc_seq_dma.sv
module adc_seq_dma
  import adc_seq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [AW-1:0]      base_i,
  input  logic [CNT_W-1:0]   target_i,
  input  logic               wr_i,
  input  logic [ENTRY_W-1:0] data_i,
  output logic               last_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [ENTRY_W-1:0] mem_wdata_o
);
  localparam logic [AW-1:0]    A_ONE = AW'(1);
  localparam logic [CNT_W-1:0] N_ONE = CNT_W'(1);

  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] n_next;

  assign n_next = n_q + N_ONE;
  // target of zero wraps to the full 2**CNT_W run
  assign last_o = (n_next == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      n_q         <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= wr_i;
      if (load_i) begin
        ptr_q <= base_i;
        n_q   <= '0;
      end else if (wr_i) begin
        mem_addr_o  <= ptr_q;
        mem_wdata_o <= data_i;
        ptr_q       <= ptr_q + A_ONE;
        n_q         <= n_next;
      end
    end
  end

  p_load_wr_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && wr_i));
  p_addr_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wr_i) |=> (mem_addr_o == $past(mem_addr_o) + A_ONE));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               cnv_pin_i,
  input  logic               tmr_pulse_i,
  output logic               conv_start_o,
  output logic [CHAN_W-1:0]  conv_chan_o,
  input  logic               conv_done_i,
  input  logic [CODE_W-1:0]  conv_code_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [ENTRY_W-1:0] mem_wdata_o,
  output logic               irq_o
);
  ctrl_t             ctrl;
  logic [AW-1:0]     cap_base;
  logic [CNT_W-1:0]  cap_cnt;
  logic              sw_start, clr, pin_fall;
  logic              trig_raw, trig;
  logic              ctrl_pwr;

  seq_st_e           st_q, st_d;
  logic              cap_run_q, cap_run_d;
  logic [CHAN_W-1:0] chan_q;
  logic [CODE_W-1:0] result_q;
  logic              done_q, ovr_q, capdone_q;
  logic              start_now, set_done, set_capdone, set_ovr;
  logic              cap_load, cap_wr, cap_last;
  logic              busy;

  adc_seq_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .ctrl_o     (ctrl),
    .base_o     (cap_base),
    .cnt_o      (cap_cnt),
    .sw_start_o (sw_start),
    .clr_o      (clr),
    .result_i   (result_q),
    .done_i     (done_q),
    .ovr_i      (ovr_q),
    .capdone_i  (capdone_q),
    .busy_i     (busy)
  );

  adc_seq_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cnv_pin_i),
    .fall_o (pin_fall)
  );

  adc_seq_dma #(.AW(AW), .CNT_W(CNT_W)) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cap_load),
    .base_i      (cap_base),
    .target_i    (cap_cnt),
    .wr_i        (cap_wr),
    .data_i      ({chan_q, conv_code_i}),
    .last_o      (cap_last),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign ctrl_pwr = ctrl.pwr;
  assign busy     = (st_q == ST_CONV);

  always_comb begin
    case (ctrl.src)
      SRC_SW:  trig_raw = sw_start;
      SRC_PIN: trig_raw = pin_fall;
      SRC_TMR: trig_raw = tmr_pulse_i;
      default: trig_raw = 1'b0;
    endcase
  end

  assign trig    = ctrl_pwr && trig_raw;
  assign set_ovr = trig && busy;

  always_comb begin
    st_d        = st_q;
    cap_run_d   = cap_run_q;
    start_now   = 1'b0;
    set_done    = 1'b0;
    set_capdone = 1'b0;
    cap_load    = 1'b0;
    cap_wr      = 1'b0;
    if (st_q == ST_IDLE) begin
      if (trig) begin
        start_now = 1'b1;
        st_d      = ST_CONV;
        cap_run_d = ctrl.cap;
        cap_load  = ctrl.cap;
      end
    end else if (conv_done_i) begin
      if (cap_run_q) begin
        cap_wr = 1'b1;
        if (cap_last) begin
          set_capdone = 1'b1;
          cap_run_d   = 1'b0;
          st_d        = ST_IDLE;
        end else if (ctrl_pwr) begin
          start_now = 1'b1;
        end else begin
          cap_run_d = 1'b0;
          st_d      = ST_IDLE;
        end
      end else begin
        set_done = 1'b1;
        if (ctrl.cont && ctrl_pwr) start_now = 1'b1;
        else                       st_d      = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cap_run_q    <= 1'b0;
      chan_q       <= '0;
      result_q     <= '0;
      done_q       <= 1'b0;
      ovr_q        <= 1'b0;
      capdone_q    <= 1'b0;
      conv_start_o <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      st_q         <= st_d;
      cap_run_q    <= cap_run_d;
      conv_start_o <= start_now;
      irq_o        <= set_done;
      if (start_now) chan_q <= map_chan(ctrl.chan);
      if (busy && conv_done_i) result_q <= conv_code_i;
      done_q    <= set_done    || (done_q    && !clr);
      ovr_q     <= set_ovr     || (ovr_q     && !clr);
      capdone_q <= set_capdone || (capdone_q && !clr);
    end
  end

  assign conv_chan_o = chan_q;

  p_start_needs_pwr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(ctrl_pwr));
  p_chan_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_chan_o <= CHAN_W'(TEMP_CHAN));
  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr) |=> ovr_q);
  p_irq_not_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mem_we_o);
  p_capdone_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(capdone_q) |-> !busy);
endmodule

// File: tb/sim_adc_trig_seq.sv
`timescale 1ns/1ps
module sim_adc_trig_seq;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pin = 1'b1;
  logic        tmr = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_code = 12'd0;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        irq;

  always #2.5 clk = ~clk;

  adc_trig_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cnv_pin_i(pin),
    .tmr_pulse_i(tmr), .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_code_i(conv_code), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .irq_o(irq)
  );

  function automatic logic [11:0] code_of(input int ch, input int n);
    return 12'(((ch + 1) * 311 + n * 53) % 4096);
  endfunction

  // converter model
  int         n_conv = 0;
  logic       m_busy = 1'b0;
  int         m_cnt = 0;
  logic [3:0] m_chan = 4'd0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (m_busy) begin
      if (m_cnt == 1) begin
        conv_done <= 1'b1;
        conv_code <= code_of(int'(m_chan), n_conv);
        n_conv    <= n_conv + 1;
        m_busy    <= 1'b0;
      end
      m_cnt <= m_cnt - 1;
    end
    if (conv_start) begin
      m_busy <= 1'b1;
      m_cnt  <= LAT;
      m_chan <= conv_chan;
    end
  end

  // event monitor
  int cyc = 0, n_start = 0, n_irq = 0, n_mem = 0, n_chain = 0;
  int start_cyc = -100, irq_cyc = -100, done_cyc = -100, wr_cyc = 0;
  logic [3:0]  seen_chan = 4'd0;
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (conv_start) begin
      n_start   <= n_start + 1;
      start_cyc <= cyc;
      seen_chan <= conv_chan;
      if (done_cyc == cyc - 1) n_chain <= n_chain + 1;
    end
    if (irq) begin
      n_irq   <= n_irq + 1;
      irq_cyc <= cyc;
    end
    if (conv_done) done_cyc <= cyc;
    if (mem_we) begin
      n_mem <= n_mem + 1;
      mem[mem_addr] <= mem_wdata;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; wr_cyc = cyc;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_irq(input int target, input int lim);
    for (int k = 0; k < lim; k++) begin
      if (n_irq >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_cap(input int lim);
    logic [15:0] d;
    for (int k = 0; k < lim; k++) begin
      rd(2'd1, d);
      if (d[14]) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int s0, i0, m0, n0, c0, pc, ds;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 capture cfg", d, 0);
    check("R1 start", conv_start, 0);
    check("R1 irq", irq, 0);
    check("R1 mem_we", mem_we, 0);

    // power down refuses triggers
    wr(2'd0, 16'h0000);
    s0 = n_start;
    wr(2'd1, 16'h0001);
    repeat (12) @(negedge clk);
    check("R2 no start when off", n_start - s0, 0);
    rd(2'd1, d); check("R2 no overrun when off", d[13], 0);

    // channel sweep, software trigger, single mode
    for (int ch = 0; ch < 16; ch++) begin
      int ec;
      ec = (ch > 8) ? 8 : ch;
      n0 = n_conv; i0 = n_irq;
      wr(2'd0, 16'(1 | (ch << 5)));
      rd(2'd0, d); check("R13 ctrl readback", d, 1 | (ch << 5));
      wr(2'd1, 16'h0001);
      wait_irq(i0 + 1, 40);
      check("R4 sw start latency", start_cyc - wr_cyc, 1);
      check("R3 channel", seen_chan, ec);
      rd(2'd1, d);
      check("R8 result", d[11:0], code_of(ec, n0));
      check("R8 done flag", d[12], 1);
      check("R8 irq one cycle after done", irq_cyc - done_cyc, 1);
      check("R8 single irq", n_irq - i0, 1);
      wr(2'd1, 16'h0002);
      rd(2'd1, d); check("R10 clear done", d[12], 0);
    end

    // overrun
    wr(2'd0, 16'(1 | (2 << 5)));
    s0 = n_start; i0 = n_irq;
    wr(2'd1, 16'h0001);
    wr(2'd1, 16'h0001);
    wait_irq(i0 + 1, 40);
    check("R10 busy trigger ignored", n_start - s0, 1);
    rd(2'd1, d); check("R10 overrun set", d[13], 1);
    wr(2'd1, 16'h0001);
    wait_irq(i0 + 2, 40);
    rd(2'd1, d); check("R10 overrun sticky", d[13], 1);
    wr(2'd1, 16'h0002);
    rd(2'd1, d); check("R10 overrun cleared", d[13], 0);

    // pin source
    wr(2'd0, 16'(1 | (1 << 2) | (4 << 5)));
    s0 = n_start; i0 = n_irq;
    wr(2'd1, 16'h0001);
    repeat (10) @(negedge clk);
    check("R7 sw ignored in pin mode", n_start - s0, 0);
    @(negedge clk); pin = 1'b0; pc = cyc;
    wait_irq(i0 + 1, 40);
    check("R5 pin latency", start_cyc - pc, 3);
    @(negedge clk); pin = 1'b1;
    repeat (10) @(negedge clk);
    check("R5 rising edge ignored", n_start - s0, 1);
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 timer ignored in pin mode", n_start - s0, 1);

    // timer source
    wr(2'd0, 16'(1 | (2 << 2) | (7 << 5)));
    s0 = n_start; i0 = n_irq;
    @(negedge clk); tmr = 1'b1; pc = cyc;
    @(negedge clk); tmr = 1'b0;
    wait_irq(i0 + 1, 40);
    check("R6 timer latency", start_cyc - pc, 1);
    check("R6 timer channel", seen_chan, 7);
    @(negedge clk); pin = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 pin ignored in timer mode", n_start - s0, 1);
    @(negedge clk); pin = 1'b1;
    repeat (5) @(negedge clk);

    // continuous mode
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'(1 | 2 | (5 << 5)));
    s0 = n_start; i0 = n_irq; c0 = n_chain;
    wr(2'd1, 16'h0001);
    wait_irq(i0 + 3, 100);
    wr(2'd0, 16'(1 | (5 << 5)));
    repeat (30) @(negedge clk);
    ds = n_start - s0;
    check("R9 repeated starts", ds >= 3, 1);
    check("R9 restart next cycle", n_chain - c0, ds - 1);
    check("R9 every run completes", n_irq - i0, ds);
    rd(2'd1, d);
    check("R9 stopped", d[15], 0);
    check("R9 last result", d[11:0], code_of(5, n_conv - 1));

    // power off during continuous
    wr(2'd0, 16'(1 | 2 | (1 << 5)));
    s0 = n_start; i0 = n_irq;
    wr(2'd1, 16'h0001);
    repeat (2) @(negedge clk);
    wr(2'd0, 16'(2 | (1 << 5)));
    repeat (30) @(negedge clk);
    check("R2 no restart after power off", n_start - s0, 1);
    check("R2 current run finishes", n_irq - i0, 1);

    // capture run
    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h0510);
    wr(2'd0, 16'(1 | (1 << 4) | (3 << 5)));
    s0 = n_start; i0 = n_irq; m0 = n_mem; n0 = n_conv;
    wr(2'd1, 16'h0001);
    wait_cap(300);
    repeat (2) @(negedge clk);
    check("R12 sample count", n_mem - m0, 5);
    check("R12 start count", n_start - s0, 5);
    for (int k = 0; k < 5; k++)
      check("R11 entry", mem[16 + k], {4'd3, code_of(3, n0 + k)});
    check("R11 no irq", n_irq - i0, 0);
    rd(2'd1, d);
    check("R11 no done flag", d[12], 0);
    check("R12 capture done", d[14], 1);
    check("R12 idle", d[15], 0);

    // capture with wrap, temperature channel, overrun during run
    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h03FE);
    wr(2'd0, 16'(1 | (1 << 4) | (12 << 5)));
    m0 = n_mem; n0 = n_conv;
    wr(2'd1, 16'h0001);
    wr(2'd1, 16'h0001);
    wait_cap(300);
    repeat (2) @(negedge clk);
    check("R12 wrap count", n_mem - m0, 3);
    check("R11 entry FE", mem[8'hFE], {4'd8, code_of(8, n0)});
    check("R11 entry FF", mem[8'hFF], {4'd8, code_of(8, n0 + 1)});
    check("R11 entry wrap 00", mem[8'h00], {4'd8, code_of(8, n0 + 2)});
    rd(2'd1, d); check("R10 overrun in capture", d[13], 1);
    rd(2'd2, d); check("R13 capture cfg readback", d, 16'h03FE);

    summary();
    $finish;
  end
endmodule